// File: doc/BRIEF.md
# Coprocessor Firmware Image Loader

The block receives a coprocessor firmware image as a stream of 32-bit words over a valid/ready handshake, together with the image's total byte length given when the load is started. It reads a five-word header, works out the byte order of the image from its first word, and checks the declared section sizes against the length and against the memory depths. The instruction section is written into an on-chip instruction memory and the data section into an on-chip data memory; each region is zeroed first. An additive checksum is then formed from the header fields and from the words read back out of both memories, and compared with the image's trailing word.

While it loads, the block holds the coprocessor in reset. When every check passes it runs a fixed release sequence: one pulse that clears both mailboxes, then clock gating is turned off, then reset is released. On any error the coprocessor stays in reset and a 2-bit status code gives the cause. If a load is requested while the coprocessor is already running and a liveness strobe reports that it is responding, no load takes place. The coprocessor reads its program and data through one read port on each memory.

The controller is a single state machine. States: `S_IDLE` (waits for `start`), `S_HDR` (accepts the five header words), `S_CLEAR` (zeroes both target regions), `S_LOAD_I` (accepts instruction words), `S_LOAD_D` (accepts data words), `S_LOAD_CK` (accepts the checksum word), `S_VERIFY` (reads back and sums both memories), `S_JUDGE` (compares the sums), `S_MB_CLR`, `S_UNGATE`, `S_UNRESET` (release steps) and `S_FINISH` (pulses `done`). Transitions: `S_IDLE`→`S_FINISH` on start when the coprocessor is running and alive, else `S_IDLE`→`S_HDR`. `S_HDR`→`S_FINISH` on a bad first word or bad sizes, else `S_HDR`→`S_CLEAR` after the fifth word. `S_CLEAR`→`S_LOAD_I`→`S_LOAD_D`→`S_LOAD_CK`→`S_VERIFY`→`S_JUDGE`, each step taken when its word count is reached. `S_JUDGE`→`S_MB_CLR` on a match, else `S_JUDGE`→`S_FINISH`. `S_MB_CLR`→`S_UNGATE`→`S_UNRESET`→`S_FINISH`→`S_IDLE`, one cycle each.

Top module: `fw_image_loader`

## Requirements
- R1: After reset, `cpu_reset` and `cpu_clk_gate` are 1, `done`, `mbox_clear` and `word_ready` are 0, and `status` is 0 (none).
- R2: The first image word must be 0xfe0101fe (little-endian image) or 0xfe1010fe (big-endian image); any other value ends the load with `status` = 1 (bad magic), no further word is accepted and `cpu_reset` stays 1.
- R3: In a big-endian image every word after the first is byte-reversed (bits 7:0 swap with 31:24, bits 15:8 with 23:16) before it is used as a header field, a memory word or the checksum; in a little-endian image words are used as received.
- R4: Word order is magic, sequence, version, instruction byte size, data byte size, then instruction-size/4 words written to instruction memory from address 0, then data-size/4 words written to data memory from address 0, then the checksum word; either section may be empty.
- R5: Both sizes must be multiples of 4, the byte length must equal 24 plus both sizes, and each section must fit its memory (exactly full is allowed); otherwise the load ends after the fifth word with `status` = 2 (bad size).
- R6: Before any section word is accepted, the addresses the new instruction and data sections occupy read as zero; addresses beyond them keep their old contents.
- R7: The 32-bit wrapping sum of the five header fields plus all words read back from both loaded regions must equal the checksum word; otherwise `status` = 3 (bad checksum), `cpu_reset` stays 1 and no mailbox pulse occurs.
- R8: On a successful load `mbox_clear` pulses for one cycle; in the next cycle `cpu_clk_gate` is 0; in the cycle after that `cpu_reset` falls; `done` follows one cycle later with `status` = 0.
- R9: A load that is not skipped drives `cpu_reset` to 1 in the cycle after `start` is taken.
- R10: A `start` while `cpu_reset` is 0 and `cpu_alive` is 1 accepts no word, leaves `cpu_reset` at 0 and the memories unchanged, and ends with `done` and `status` = 0.
- R11: `done` is a one-cycle pulse at the end of every load attempt; `status` holds its value until the next `start`; `word_ready` is 0 whenever `done` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a load attempt (taken in idle only) |
| img_bytes | input | 32 | Total image length in bytes, sampled with `start` |
| cpu_alive | input | 1 | Coprocessor reports it is responding |
| word_valid | input | 1 | Image word present |
| word_data | input | 32 | Image word |
| word_ready | output | 1 | Block accepts the word this cycle |
| cpu_reset | output | 1 | Coprocessor reset control (1 = held) |
| cpu_clk_gate | output | 1 | Coprocessor clock gating (1 = clock stopped) |
| mbox_clear | output | 1 | One-cycle pulse clearing both mailboxes |
| done | output | 1 | One-cycle end-of-attempt pulse |
| status | output | 2 | 0 none, 1 bad magic, 2 bad size, 3 bad checksum |
| imem_rd_addr | input | IAW | Coprocessor instruction memory read address |
| imem_rd_data | output | 32 | Instruction memory read data, one cycle after address |
| dmem_rd_addr | input | DAW | Coprocessor data memory read address |
| dmem_rd_data | output | 32 | Data memory read data, one cycle after address |

## Verification
A state machine stuck or skipping a state shows as `word_ready` rising or falling at the wrong word count, which breaks the word order and surfaces at `done` as a wrong status or as wrong words read from the memory ports within a few cycles of the end of the load. A wrong byte-order flag or a missed clear changes the read-back sum and so turns a good image into status 3 at the same `done`. A slip in the release steps moves `mbox_clear`, the clock-gate fall and the reset fall off their consecutive cycles, visible in the very cycles they occur.

// File: rtl/fwl_pkg.sv
package fwl_pkg;

    localparam logic [31:0] MAGIC_LITTLE = 32'hfe0101fe;
    localparam logic [31:0] MAGIC_BIG    = 32'hfe1010fe;
    localparam int          HDR_WORDS    = 5;
    localparam int          FIXED_BYTES  = 24;

    typedef enum logic [1:0] {
        ST_OK    = 2'd0,
        ST_MAGIC = 2'd1,
        ST_SIZE  = 2'd2,
        ST_CKSUM = 2'd3
    } fwl_status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HDR,
        S_CLEAR,
        S_LOAD_I,
        S_LOAD_D,
        S_LOAD_CK,
        S_VERIFY,
        S_JUDGE,
        S_MB_CLR,
        S_UNGATE,
        S_UNRESET,
        S_FINISH
    } fwl_state_e;

endpackage

// File: rtl/fwl_byte_order.sv
module fwl_byte_order #(
    parameter int BYTES = 4
) (
    input  logic               reverse,
    input  logic [8*BYTES-1:0] din,
    output logic [8*BYTES-1:0] dout
);
    logic [8*BYTES-1:0] flipped;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        assign flipped[8*b +: 8] = din[8*(BYTES-1-b) +: 8];
    end

    assign dout = reverse ? flipped : din;
endmodule

// File: rtl/fwl_word_mem.sv
module fwl_word_mem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 32,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
        rdata_a <= cells[raddr_a];
        rdata_b <= cells[raddr_b];
    end
endmodule

// File: rtl/fwl_hdr_check.sv
module fwl_hdr_check #(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64
) (
    input  logic [31:0] first_word,
    input  logic [31:0] isz_bytes,
    input  logic [31:0] dsz_bytes,
    input  logic [31:0] total_bytes,
    output logic        magic_ok,
    output logic        magic_big,
    output logic        size_ok
);
    import fwl_pkg::*;

    logic [33:0] expect_len;
    logic        aligned;
    logic        fits;

    assign magic_big  = (first_word == MAGIC_BIG);
    assign magic_ok   = magic_big || (first_word == MAGIC_LITTLE);
    assign aligned    = (isz_bytes[1:0] == 2'b00) && (dsz_bytes[1:0] == 2'b00);
    assign fits       = ((isz_bytes >> 2) <= 32'(IMEM_WORDS)) &&
                        ((dsz_bytes >> 2) <= 32'(DMEM_WORDS));
    assign expect_len = {2'b00, isz_bytes} + {2'b00, dsz_bytes} + 34'(FIXED_BYTES);
    assign size_ok    = aligned && fits && (expect_len == {2'b00, total_bytes});
endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader #(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    parameter int IAW        = (IMEM_WORDS > 1) ? $clog2(IMEM_WORDS) : 1,
    parameter int DAW        = (DMEM_WORDS > 1) ? $clog2(DMEM_WORDS) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [31:0]    img_bytes,
    input  logic           cpu_alive,
    input  logic           word_valid,
    input  logic [31:0]    word_data,
    output logic           word_ready,
    output logic           cpu_reset,
    output logic           cpu_clk_gate,
    output logic           mbox_clear,
    output logic           done,
    output logic [1:0]     status,
    input  logic [IAW-1:0] imem_rd_addr,
    output logic [31:0]    imem_rd_data,
    input  logic [DAW-1:0] dmem_rd_addr,
    output logic [31:0]    dmem_rd_data
);
    import fwl_pkg::*;

    localparam int MAX_WORDS = (IMEM_WORDS > DMEM_WORDS) ? IMEM_WORDS : DMEM_WORDS;
    localparam int CNT_W     = $clog2(MAX_WORDS + 1);

    fwl_state_e        state_q, state_d;
    fwl_status_e       status_q;
    logic              be_q;
    logic [2:0]        hdr_q;
    logic [31:0]       isz_q, len_q, acc_q, ck_q;
    logic [CNT_W-1:0]  iw_q, dw_q, idx_q, pidx_q, nmax;
    logic              pend_q;
    logic              rst_q, gate_q, mbox_q, done_q;

    logic [31:0]       w_sw;
    logic              rdy, take, step;
    logic              magic_ok, magic_big, size_ok;

    logic              i_we, d_we;
    logic [31:0]       i_wdata, d_wdata, i_rd, d_rd;

    assign nmax = (iw_q > dw_q) ? iw_q : dw_q;

    fwl_byte_order #(.BYTES(4)) u_order (
        .reverse (be_q),
        .din     (word_data),
        .dout    (w_sw)
    );

    fwl_hdr_check #(.IMEM_WORDS(IMEM_WORDS), .DMEM_WORDS(DMEM_WORDS)) u_hdr (
        .first_word  (word_data),
        .isz_bytes   (isz_q),
        .dsz_bytes   (w_sw),
        .total_bytes (len_q),
        .magic_ok    (magic_ok),
        .magic_big   (magic_big),
        .size_ok     (size_ok)
    );

    // handshake: ready only while a word of the current field is still due
    always_comb begin
        unique case (state_q)
            S_HDR:     rdy = 1'b1;
            S_LOAD_I:  rdy = (idx_q < iw_q);
            S_LOAD_D:  rdy = (idx_q < dw_q);
            S_LOAD_CK: rdy = 1'b1;
            default:   rdy = 1'b0;
        endcase
    end

    assign take = word_valid && rdy;

    always_comb begin
        unique case (state_q)
            S_CLEAR:  step = (idx_q < nmax);
            S_LOAD_I: step = take;
            S_LOAD_D: step = take;
            S_VERIFY: step = (idx_q < nmax);
            default:  step = 1'b0;
        endcase
    end

    // memory write side: zero fill during clear, image words during load
    assign i_we    = ((state_q == S_CLEAR) && (idx_q < iw_q)) || ((state_q == S_LOAD_I) && take);
    assign d_we    = ((state_q == S_CLEAR) && (idx_q < dw_q)) || ((state_q == S_LOAD_D) && take);
    assign i_wdata = (state_q == S_LOAD_I) ? w_sw : 32'd0;
    assign d_wdata = (state_q == S_LOAD_D) ? w_sw : 32'd0;

    fwl_word_mem #(.DEPTH(IMEM_WORDS), .WIDTH(32), .AW(IAW)) u_imem (
        .clk     (clk),
        .we      (i_we),
        .waddr   (IAW'(idx_q)),
        .wdata   (i_wdata),
        .raddr_a (IAW'(idx_q)),
        .rdata_a (i_rd),
        .raddr_b (imem_rd_addr),
        .rdata_b (imem_rd_data)
    );

    fwl_word_mem #(.DEPTH(DMEM_WORDS), .WIDTH(32), .AW(DAW)) u_dmem (
        .clk     (clk),
        .we      (d_we),
        .waddr   (DAW'(idx_q)),
        .wdata   (d_wdata),
        .raddr_a (DAW'(idx_q)),
        .rdata_a (d_rd),
        .raddr_b (dmem_rd_addr),
        .rdata_b (dmem_rd_data)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    state_d = (!rst_q && cpu_alive) ? S_FINISH : S_HDR;
                end
            end
            S_HDR: begin
                if (take) begin
                    if (hdr_q == 3'd0 && !magic_ok) begin
                        state_d = S_FINISH;
                    end else if (hdr_q == 3'(HDR_WORDS - 1)) begin
                        state_d = size_ok ? S_CLEAR : S_FINISH;
                    end
                end
            end
            S_CLEAR:   if (idx_q >= nmax) state_d = S_LOAD_I;
            S_LOAD_I:  if (idx_q >= iw_q) state_d = S_LOAD_D;
            S_LOAD_D:  if (idx_q >= dw_q) state_d = S_LOAD_CK;
            S_LOAD_CK: if (take) state_d = S_VERIFY;
            S_VERIFY:  if (idx_q >= nmax && !pend_q) state_d = S_JUDGE;
            S_JUDGE:   state_d = (acc_q == ck_q) ? S_MB_CLR : S_FINISH;
            S_MB_CLR:  state_d = S_UNGATE;
            S_UNGATE:  state_d = S_UNRESET;
            S_UNRESET: state_d = S_FINISH;
            S_FINISH:  state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= ST_OK;
            be_q     <= 1'b0;
            hdr_q    <= 3'd0;
            isz_q    <= 32'd0;
            len_q    <= 32'd0;
            acc_q    <= 32'd0;
            ck_q     <= 32'd0;
            iw_q     <= '0;
            dw_q     <= '0;
            idx_q    <= '0;
            pidx_q   <= '0;
            pend_q   <= 1'b0;
            rst_q    <= 1'b1;
            gate_q   <= 1'b1;
            mbox_q   <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            mbox_q <= 1'b0;
            done_q <= 1'b0;
            pend_q <= (state_q == S_VERIFY) && (idx_q < nmax);
            pidx_q <= idx_q;

            if (state_d != state_q) begin
                idx_q <= '0;
            end else if (step) begin
                idx_q <= idx_q + CNT_W'(1);
            end

            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        len_q    <= img_bytes;
                        acc_q    <= 32'd0;
                        hdr_q    <= 3'd0;
                        be_q     <= 1'b0;
                        status_q <= ST_OK;
                        if (rst_q || !cpu_alive) begin
                            rst_q <= 1'b1;
                        end
                    end
                end
                S_HDR: begin
                    if (take) begin
                        hdr_q <= hdr_q + 3'd1;
                        acc_q <= acc_q + w_sw;
                        if (hdr_q == 3'd0) begin
                            be_q <= magic_big;
                            if (!magic_ok) status_q <= ST_MAGIC;
                        end
                        if (hdr_q == 3'd3) begin
                            isz_q <= w_sw;
                        end
                        if (hdr_q == 3'(HDR_WORDS - 1)) begin
                            if (!size_ok) status_q <= ST_SIZE;
                            iw_q <= CNT_W'(isz_q >> 2);
                            dw_q <= CNT_W'(w_sw >> 2);
                        end
                    end
                end
                S_LOAD_CK: begin
                    if (take) ck_q <= w_sw;
                end
                S_VERIFY: begin
                    if (pend_q) begin
                        acc_q <= acc_q + ((pidx_q < iw_q) ? i_rd : 32'd0)
                                       + ((pidx_q < dw_q) ? d_rd : 32'd0);
                    end
                end
                S_JUDGE: begin
                    if (acc_q != ck_q) status_q <= ST_CKSUM;
                end
                S_MB_CLR:  mbox_q <= 1'b1;
                S_UNGATE:  gate_q <= 1'b0;
                S_UNRESET: rst_q  <= 1'b0;
                S_FINISH:  done_q <= 1'b1;
                default: ;
            endcase
        end
    end

    assign word_ready   = rdy;
    assign cpu_reset    = rst_q;
    assign cpu_clk_gate = gate_q;
    assign mbox_clear   = mbox_q;
    assign done         = done_q;
    assign status       = status_q;
endmodule

// File: rtl/fwl_checker.sv
module fwl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       word_ready,
    input logic       cpu_reset,
    input logic       cpu_clk_gate,
    input logic       mbox_clear,
    input logic       done,
    input logic [1:0] status
);
    assert_gate_after_mbox_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_clk_gate) |-> $past(mbox_clear));

    assert_reset_after_ungate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_reset) |-> !cpu_clk_gate && !mbox_clear);

    assert_mbox_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_clear |=> !mbox_clear);

    assert_mbox_while_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mbox_clear |-> cpu_reset);

    assert_error_keeps_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != 2'd0) |-> cpu_reset);

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_ready_at_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !word_ready);
endmodule

bind fw_image_loader fwl_checker u_fwl_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .word_ready   (word_ready),
    .cpu_reset    (cpu_reset),
    .cpu_clk_gate (cpu_clk_gate),
    .mbox_clear   (mbox_clear),
    .done         (done),
    .status       (status)
);

// File: tb/tb_fw_image_loader.sv
module tb_fw_image_loader;
    localparam int CLK_PERIOD = 10;
    localparam int IW  = 64;
    localparam int DW  = 64;
    localparam int IAW = 6;
    localparam int DAW = 6;
    localparam logic [31:0] M_LE = 32'hfe0101fe;
    localparam logic [31:0] M_BE = 32'hfe1010fe;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [31:0]    img_bytes = '0;
    logic           cpu_alive = 1'b0;
    logic           word_valid = 1'b0;
    logic [31:0]    word_data = '0;
    logic           word_ready, cpu_reset, cpu_clk_gate, mbox_clear, done;
    logic [1:0]     status;
    logic [IAW-1:0] imem_rd_addr = '0;
    logic [31:0]    imem_rd_data;
    logic [DAW-1:0] dmem_rd_addr = '0;
    logic [31:0]    dmem_rd_data;

    fw_image_loader #(.IMEM_WORDS(IW), .DMEM_WORDS(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .img_bytes(img_bytes),
        .cpu_alive(cpu_alive), .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .cpu_reset(cpu_reset), .cpu_clk_gate(cpu_clk_gate),
        .mbox_clear(mbox_clear), .done(done), .status(status),
        .imem_rd_addr(imem_rd_addr), .imem_rd_data(imem_rd_data),
        .dmem_rd_addr(dmem_rd_addr), .dmem_rd_data(dmem_rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    logic [31:0] img [0:79];
    int          img_n;
    logic [31:0] hi [0:63];
    logic [31:0] hd [0:63];

    int mb_at, gf_at, rf_at, dn_at;
    bit ready_seen;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] swap32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    // builds host-order contents and wire-order image; returns byte length
    task automatic build(input int iw, input int dw, input int seed,
                         input bit be, input bit bad_ck, output int len);
        logic [31:0] hw [0:79];
        logic [31:0] sum;
        int n;
        hw[0] = be ? M_BE : M_LE;
        hw[1] = {16'd3, 16'(seed)};
        hw[2] = 32'h0102_0000 + 32'(seed);
        hw[3] = 32'(4 * iw);
        hw[4] = 32'(4 * dw);
        n = 5;
        for (int k = 0; k < iw; k++) begin
            hi[k] = 32'hF100_0000 ^ (32'(seed) << 8) ^ (32'(k) * 32'h0001_0001);
            hw[n] = hi[k];
            n++;
        end
        for (int k = 0; k < dw; k++) begin
            hd[k] = 32'hE200_0000 ^ (32'(k) * 32'h0100_0101) ^ 32'(seed);
            hw[n] = hd[k];
            n++;
        end
        sum = 32'd0;
        for (int k = 0; k < n; k++) sum = sum + hw[k];
        hw[n] = bad_ck ? sum + 32'd1 : sum;
        n++;
        for (int k = 0; k < n; k++) img[k] = be ? swap32(hw[k]) : hw[k];
        img_n = n;
        len = 4 * n;
    endtask

    task automatic push(input logic [31:0] w);
        word_valid = 1'b1;
        word_data  = w;
        while (!word_ready) @(negedge clk);
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic begin_load(input int len);
        @(negedge clk);
        start     = 1'b1;
        img_bytes = 32'(len);
        @(negedge clk);
        start     = 1'b0;
    endtask

    task automatic wait_done();
        bit pg, pr;
        mb_at = -1; gf_at = -1; rf_at = -1; dn_at = -1;
        ready_seen = 1'b0;
        pg = cpu_clk_gate;
        pr = cpu_reset;
        for (int t = 0; t < 3000; t++) begin
            if (mbox_clear) mb_at = t;
            if (pg && !cpu_clk_gate) gf_at = t;
            if (pr && !cpu_reset) rf_at = t;
            if (word_ready) ready_seen = 1'b1;
            pg = cpu_clk_gate;
            pr = cpu_reset;
            if (done) begin
                dn_at = t;
                break;
            end
            @(negedge clk);
        end
        chk("R11", "done seen", 32'(dn_at >= 0), 32'd1);
    endtask

    task automatic rd_i(input int a, output logic [31:0] v);
        @(negedge clk);
        imem_rd_addr = IAW'(a);
        @(negedge clk);
        v = imem_rd_data;
    endtask

    task automatic rd_d(input int a, output logic [31:0] v);
        @(negedge clk);
        dmem_rd_addr = DAW'(a);
        @(negedge clk);
        v = dmem_rd_data;
    endtask

    task automatic push_all();
        for (int k = 0; k < img_n; k++) push(img[k]);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        chk("R1", "cpu_reset", 32'(cpu_reset), 32'd1);
        chk("R1", "cpu_clk_gate", 32'(cpu_clk_gate), 32'd1);
        chk("R1", "done", 32'(done), 32'd0);
        chk("R1", "mbox_clear", 32'(mbox_clear), 32'd0);
        chk("R1", "word_ready", 32'(word_ready), 32'd0);
        chk("R1", "status", 32'(status), 32'd0);
    endtask

    task automatic t_little_endian();
        int len; logic [31:0] v;
        build(5, 3, 1, 1'b0, 1'b0, len);
        cpu_alive = 1'b0;
        begin_load(len);
        push_all();
        wait_done();
        chk("R7", "status good image", 32'(status), 32'd0);
        chk("R8", "gate falls after mailbox", 32'(gf_at - mb_at), 32'd1);
        chk("R8", "reset falls after gate", 32'(rf_at - gf_at), 32'd1);
        chk("R8", "done after reset release", 32'(dn_at - rf_at), 32'd1);
        chk("R8", "cpu_reset low", 32'(cpu_reset), 32'd0);
        chk("R8", "cpu_clk_gate low", 32'(cpu_clk_gate), 32'd0);
        @(negedge clk);
        chk("R11", "done one cycle", 32'(done), 32'd0);
        chk("R11", "status held", 32'(status), 32'd0);
        rd_i(0, v); chk("R4", "imem[0]", v, hi[0]);
        rd_i(4, v); chk("R4", "imem[4]", v, hi[4]);
        rd_d(0, v); chk("R4", "dmem[0]", v, hd[0]);
        rd_d(2, v); chk("R4", "dmem[2]", v, hd[2]);
    endtask

    task automatic t_big_endian();
        int len; logic [31:0] v;
        build(4, 6, 2, 1'b1, 1'b0, len);
        cpu_alive = 1'b0;
        begin_load(len);
        chk("R9", "reset reasserted after start", 32'(cpu_reset), 32'd1);
        push_all();
        wait_done();
        chk("R3", "status big-endian image", 32'(status), 32'd0);
        chk("R8", "reset release follows mailbox", 32'(rf_at - mb_at), 32'd2);
        rd_i(3, v); chk("R3", "imem[3] reversed", v, hi[3]);
        rd_d(5, v); chk("R3", "dmem[5] reversed", v, hd[5]);
        rd_d(0, v); chk("R3", "dmem[0] reversed", v, hd[0]);
    endtask

    task automatic t_skip();
        logic [31:0] v;
        cpu_alive = 1'b1;
        begin_load(100);
        wait_done();
        cpu_alive = 1'b0;
        chk("R10", "status", 32'(status), 32'd0);
        chk("R10", "no word accepted", 32'(ready_seen), 32'd0);
        chk("R10", "cpu_reset stays low", 32'(cpu_reset), 32'd0);
        rd_i(0, v); chk("R10", "imem[0] kept", v, hi[0]);
    endtask

    task automatic t_clear_then_bad_sum();
        int len; logic [31:0] v, old_i3, old_d4;
        old_i3 = hi[3];
        old_d4 = hd[4];
        build(2, 2, 5, 1'b0, 1'b1, len);
        cpu_alive = 1'b0;
        begin_load(len);
        for (int k = 0; k < 5; k++) push(img[k]);
        while (!word_ready) @(negedge clk);
        rd_i(1, v); chk("R6", "imem[1] cleared", v, 32'd0);
        rd_d(1, v); chk("R6", "dmem[1] cleared", v, 32'd0);
        rd_i(3, v); chk("R6", "imem[3] outside region kept", v, old_i3);
        rd_d(4, v); chk("R6", "dmem[4] outside region kept", v, old_d4);
        for (int k = 5; k < img_n; k++) push(img[k]);
        wait_done();
        chk("R7", "status bad checksum", 32'(status), 32'd3);
        chk("R7", "cpu_reset held", 32'(cpu_reset), 32'd1);
        chk("R7", "no mailbox pulse", 32'(mb_at), 32'hFFFF_FFFF);
    endtask

    task automatic t_bad_magic();
        cpu_alive = 1'b0;
        begin_load(40);
        push(32'h1234_5678);
        wait_done();
        chk("R2", "status bad magic", 32'(status), 32'd1);
        chk("R2", "no further words", 32'(ready_seen), 32'd0);
        chk("R2", "cpu_reset held", 32'(cpu_reset), 32'd1);
    endtask

    task automatic hdr_only(input logic [31:0] isz, input logic [31:0] dsz,
                            input int len, input string what);
        begin_load(len);
        push(M_LE);
        push(32'h0001_0001);
        push(32'h0000_0007);
        push(isz);
        push(dsz);
        wait_done();
        chk("R5", what, 32'(status), 32'd2);
        chk("R5", "no section word taken", 32'(ready_seen), 32'd0);
    endtask

    task automatic t_sizes();
        hdr_only(32'd6, 32'd8, 38, "unaligned instruction size");
        hdr_only(32'd8, 32'd8, 44, "length mismatch");
        hdr_only(32'd260, 32'd4, 288, "instruction section too big");
        hdr_only(32'd4, 32'd260, 288, "data section too big");
    endtask

    task automatic t_boundaries();
        int len; logic [31:0] v;
        cpu_alive = 1'b0;
        build(0, 0, 7, 1'b0, 1'b0, len);
        begin_load(len);
        push_all();
        wait_done();
        chk("R4", "empty sections accepted", 32'(status), 32'd0);
        chk("R4", "empty load releases", 32'(cpu_reset), 32'd0);
        build(64, 1, 9, 1'b1, 1'b0, len);
        begin_load(len);
        push_all();
        wait_done();
        chk("R5", "full instruction memory accepted", 32'(status), 32'd0);
        rd_i(63, v); chk("R5", "imem[63]", v, hi[63]);
        rd_d(0, v);  chk("R5", "dmem[0]", v, hd[0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_little_endian();
        t_big_endian();
        t_skip();
        t_clear_then_bad_sum();
        t_bad_magic();
        t_sizes();
        t_boundaries();
        repeat (2) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule